// File: doc/BRIEF.md
# Free-Running Monitor Test Pattern Generator

This block produces a complete video timing set on its own, with no incoming sync, so that a display can be burned in or checked by an end user. From a single reference clock it counts out lines and frames. It drives a horizontal timing output, a vertical timing output and a one-bit pattern video signal that is kept apart from the two timing outputs.

Four line rates and two frame rates can be selected. With the default 12 MHz clock the line rates are about 95.2 kHz, 63.5 kHz, 47.6 kHz and 31.75 kHz, and the frame rates are 72 Hz and 60 Hz. Four pictures can be selected: a grid of lines on black, the same grid inverted, a solid white field and a solid black field.

Rate and picture selections are taken only at frame boundaries, so a frame is never drawn partly in one setting and partly in another. Dropping the enable silences every output. Raising it again restarts the sequence at the first pixel of a new frame.

Top module: `stg_selftest_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until `en` is sampled high, `h_out`, `v_out` and `video_out` are all 0.
- R2: The line period in clocks is LINE_UNIT times 2, 3, 4 or 6 for `rate_sel` = 0, 1, 2 or 3. The defaults give 126, 189, 252 and 378 clocks.
- R3: A frame has round(CLK_HZ / (line period × F)) lines. F is FRAME_HZ_A (72) when `frame_sel` = 0 and FRAME_HZ_B (60) when `frame_sel` = 1.
- R4: `h_out` is high for the first max(1, floor(line period × H_SYNC_PCT / 100)) clocks of every line and low for the rest of the line.
- R5: `v_out` is high for every clock of the first V_SYNC_LINES lines of a frame and low on all other lines.
- R6: `pat_sel` = 0 selects the positive grid. In the active area, define ax as the pixel index minus the horizontal sync width and ay as the line index minus V_SYNC_LINES. `video_out` is 1 where ax or ay is a multiple of 2^HATCH_LOG2, on the last pixel of a line and on the last line of a frame. It is 0 elsewhere.
- R7: `pat_sel` = 1 selects the negative grid. Within the active area, `video_out` is the inverse of the R6 value.
- R8: Within the active area, `pat_sel` = 2 gives `video_out` = 1 on every pixel and `pat_sel` = 3 gives 0 on every pixel.
- R9: `video_out` is 0 on every clock where `h_out` or `v_out` is high, for every pattern.
- R10: `rate_sel`, `frame_sel` and `pat_sel` are sampled only on the last clock of a frame or while the generator is idle. A change in the middle of a frame has no effect until the next frame starts.
- R11: One clock after `en` is sampled low, all outputs are 0. The clock after `en` is next sampled high shows pixel 0 of line 0, drawn with the selections present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| rate_sel | input | 2 | Line rate select |
| frame_sel | input | 1 | Frame rate select |
| pat_sel | input | 2 | Picture select |
| h_out | output | 1 | Horizontal timing pulse, active high |
| v_out | output | 1 | Vertical timing pulse, active high |
| video_out | output | 1 | Pattern video bit |

## Verification
The bench builds the block with CLK_HZ = 24000, LINE_UNIT = 8 and HATCH_LOG2 = 2. With these values lines are 16 to 48 clocks long and frames are 7 to 25 lines long. Every combination of line rate, frame rate and picture can therefore be compared pixel by pixel over two whole frames, with the grid repeating several times per frame. The same small frames let the bench place selection changes and enable drops at chosen points inside a frame and follow the restart that comes after them.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [1:0] {
    PAT_GRID_POS = 2'd0,
    PAT_GRID_NEG = 2'd1,
    PAT_WHITE    = 2'd2,
    PAT_BLACK    = 2'd3
  } pat_e;

  typedef struct packed {
    logic [1:0] rate;
    logic       frame;
    pat_e       pat;
  } cfg_t;

  // Line period multiple of the base unit for each rate code.
  function automatic int unsigned rate_mult(input int unsigned code);
    case (code)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int unsigned div_round(input int unsigned num, input int unsigned den);
    return (num + den / 2) / den;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/stg_line_timer.sv
module stg_line_timer #(
  parameter int unsigned X_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [X_W-1:0] line_len,
  input  logic [X_W-1:0] hsw,
  output logic [X_W-1:0] x,
  output logic           line_end,
  output logic           in_hsync
);

  logic [X_W-1:0] x_d;
  logic           at_last;

  always_comb begin
    at_last = (x == line_len - X_W'(1));
    if (!go)          x_d = '0;
    else if (at_last) x_d = '0;
    else              x_d = x + X_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x <= '0;
    else        x <= x_d;
  end

  assign line_end = go & at_last;
  assign in_hsync = (x < hsw);

endmodule

// File: rtl/stg_frame_timer.sv
module stg_frame_timer #(
  parameter int unsigned Y_W          = 11,
  parameter int unsigned V_SYNC_LINES = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           line_end,
  input  logic [Y_W-1:0] frame_len,
  output logic [Y_W-1:0] y,
  output logic           frame_end,
  output logic           in_vsync
);

  logic [Y_W-1:0] y_d;
  logic           on_last;

  always_comb begin
    on_last = (y == frame_len - Y_W'(1));
    y_d     = y;
    if (!go)           y_d = '0;
    else if (line_end) y_d = on_last ? '0 : y + Y_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= '0;
    else        y <= y_d;
  end

  assign frame_end = line_end & on_last;
  assign in_vsync  = (y < Y_W'(V_SYNC_LINES));

endmodule

// File: rtl/stg_pattern.sv
module stg_pattern
  import stg_pkg::*;
#(
  parameter int unsigned X_W          = 9,
  parameter int unsigned Y_W          = 11,
  parameter int unsigned V_SYNC_LINES = 3,
  parameter int unsigned HATCH_LOG2   = 4
) (
  input  logic           active,
  input  logic [X_W-1:0] x,
  input  logic [Y_W-1:0] y,
  input  logic [X_W-1:0] hsw,
  input  logic [X_W-1:0] line_len,
  input  logic [Y_W-1:0] frame_len,
  input  pat_e           pat,
  output logic           pix
);

  localparam logic [X_W-1:0] XMASK = X_W'((1 << HATCH_LOG2) - 1);
  localparam logic [Y_W-1:0] YMASK = Y_W'((1 << HATCH_LOG2) - 1);

  logic [X_W-1:0] ax;
  logic [Y_W-1:0] ay;
  logic           grid;

  always_comb begin
    ax   = x - hsw;
    ay   = y - Y_W'(V_SYNC_LINES);
    grid = ((ax & XMASK) == '0) || ((ay & YMASK) == '0) ||
           (x == line_len - X_W'(1)) || (y == frame_len - Y_W'(1));
    case (pat)
      PAT_GRID_POS: pix = active & grid;
      PAT_GRID_NEG: pix = active & ~grid;
      PAT_WHITE:    pix = active;
      default:      pix = 1'b0;
    endcase
  end

endmodule

// File: rtl/stg_selftest_gen.sv
module stg_selftest_gen
  import stg_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 12_000_000,
  parameter int unsigned LINE_UNIT    = 63,
  parameter int unsigned FRAME_HZ_A   = 72,
  parameter int unsigned FRAME_HZ_B   = 60,
  parameter int unsigned H_SYNC_PCT   = 8,
  parameter int unsigned V_SYNC_LINES = 3,
  parameter int unsigned HATCH_LOG2   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate_sel,
  input  logic       frame_sel,
  input  logic [1:0] pat_sel,
  output logic       h_out,
  output logic       v_out,
  output logic       video_out
);

  localparam int unsigned LINE_MAX  = LINE_UNIT * 6;
  localparam int unsigned FRAME_MAX = max_u(div_round(CLK_HZ, LINE_UNIT * 2 * FRAME_HZ_A),
                                            div_round(CLK_HZ, LINE_UNIT * 2 * FRAME_HZ_B));
  localparam int unsigned X_W       = $clog2(LINE_MAX + 1);
  localparam int unsigned Y_W       = $clog2(FRAME_MAX + 1);

  // Reset: asserted at once, removed on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // Per-rate constants.
  logic [X_W-1:0] len_tab [4];
  logic [X_W-1:0] hsw_tab [4];
  logic [Y_W-1:0] frm_tab [8];

  for (genvar r = 0; r < 4; r++) begin : g_rate
    localparam int unsigned LEN = LINE_UNIT * rate_mult(r);
    localparam int unsigned HSW = max_u(1, LEN * H_SYNC_PCT / 100);
    assign len_tab[r] = X_W'(LEN);
    assign hsw_tab[r] = X_W'(HSW);
    for (genvar f = 0; f < 2; f++) begin : g_frm
      localparam int unsigned HZ = (f == 0) ? FRAME_HZ_A : FRAME_HZ_B;
      assign frm_tab[r*2+f] = Y_W'(div_round(CLK_HZ, LEN * HZ));
    end
  end

  // Run state and selection latch.
  logic           run_q;
  logic           go;
  logic           cfg_load;
  cfg_t           cfg_q;
  cfg_t           cfg_next;
  logic [X_W-1:0] line_len;
  logic [X_W-1:0] hsw;
  logic [Y_W-1:0] frame_len;
  logic [X_W-1:0] x_cnt;
  logic [Y_W-1:0] y_cnt;
  logic           line_end;
  logic           frame_end;
  logic           in_hsync;
  logic           in_vsync;
  logic           active;
  logic           pix;

  always_comb begin
    go             = run_q & en;
    cfg_load       = ~run_q | frame_end;
    cfg_next.rate  = rate_sel;
    cfg_next.frame = frame_sel;
    cfg_next.pat   = pat_e'(pat_sel);
    line_len       = len_tab[cfg_q.rate];
    hsw            = hsw_tab[cfg_q.rate];
    frame_len      = frm_tab[{cfg_q.rate, cfg_q.frame}];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= en;
      if (cfg_load) cfg_q <= cfg_next;
    end
  end

  stg_line_timer #(.X_W(X_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go       (go),
    .line_len (line_len),
    .hsw      (hsw),
    .x        (x_cnt),
    .line_end (line_end),
    .in_hsync (in_hsync)
  );

  stg_frame_timer #(.Y_W(Y_W), .V_SYNC_LINES(V_SYNC_LINES)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go        (go),
    .line_end  (line_end),
    .frame_len (frame_len),
    .y         (y_cnt),
    .frame_end (frame_end),
    .in_vsync  (in_vsync)
  );

  assign active = run_q & ~in_hsync & ~in_vsync;

  stg_pattern #(
    .X_W(X_W), .Y_W(Y_W), .V_SYNC_LINES(V_SYNC_LINES), .HATCH_LOG2(HATCH_LOG2)
  ) u_pat (
    .active    (active),
    .x         (x_cnt),
    .y         (y_cnt),
    .hsw       (hsw),
    .line_len  (line_len),
    .frame_len (frame_len),
    .pat       (cfg_q.pat),
    .pix       (pix)
  );

  assign h_out     = run_q & in_hsync;
  assign v_out     = run_q & in_vsync;
  assign video_out = pix;

endmodule

// File: rtl/stg_selftest_gen_chk.sv
module stg_selftest_gen_chk
  import stg_pkg::*;
#(
  parameter int unsigned X_W = 9,
  parameter int unsigned Y_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           h_out,
  input logic           v_out,
  input logic           video_out,
  input logic           run_q,
  input logic           go,
  input logic           frame_end,
  input logic [X_W-1:0] x_cnt,
  input logic [Y_W-1:0] y_cnt,
  input logic [X_W-1:0] line_len,
  input logic [Y_W-1:0] frame_len,
  input cfg_t           cfg_q
);

  AST_X_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    x_cnt < line_len); // R2

  AST_X_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && x_cnt == line_len - X_W'(1)) |=> (x_cnt == '0)); // R2

  AST_Y_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    y_cnt < frame_len); // R3

  AST_HSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && x_cnt == '0) |-> h_out); // R4

  AST_VSYNC_RISE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_out) |-> (x_cnt == '0 && y_cnt == '0)); // R5

  AST_WHITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cfg_q.pat == PAT_WHITE && !h_out && !v_out) |-> video_out); // R8

  AST_VIDEO_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (h_out || v_out) |-> !video_out); // R9

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !frame_end) |=> $stable(cfg_q)); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!h_out && !v_out && !video_out)); // R11

endmodule

bind stg_selftest_gen stg_selftest_gen_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .h_out     (h_out),
  .v_out     (v_out),
  .video_out (video_out),
  .run_q     (run_q),
  .go        (go),
  .frame_end (frame_end),
  .x_cnt     (x_cnt),
  .y_cnt     (y_cnt),
  .line_len  (line_len),
  .frame_len (frame_len),
  .cfg_q     (cfg_q)
);

// File: tb/stg_selftest_gen_bench.sv
module stg_selftest_gen_bench;

  localparam int CLK_P  = 10;
  localparam int P_CLK  = 24000;
  localparam int P_UNIT = 8;
  localparam int P_FA   = 72;
  localparam int P_FB   = 60;
  localparam int P_HPCT = 8;
  localparam int P_VSL  = 3;
  localparam int P_HL   = 2;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [1:0] rate_sel;
  logic       frame_sel;
  logic [1:0] pat_sel;
  logic       h_out;
  logic       v_out;
  logic       video_out;

  stg_selftest_gen #(
    .CLK_HZ(P_CLK), .LINE_UNIT(P_UNIT), .FRAME_HZ_A(P_FA), .FRAME_HZ_B(P_FB),
    .H_SYNC_PCT(P_HPCT), .V_SYNC_LINES(P_VSL), .HATCH_LOG2(P_HL)
  ) u_stg_selftest_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel), .frame_sel(frame_sel),
    .pat_sel(pat_sel), .h_out(h_out), .v_out(v_out), .video_out(video_out)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "";

  // Reference model state.
  bit m_run = 0;
  int m_x = 0, m_y = 0, m_rate = 0, m_frm = 0, m_pat = 0;
  bit m_fe = 0;

  function automatic int f_line(int r);
    int mult;
    mult = (r == 0) ? 2 : (r == 1) ? 3 : (r == 2) ? 4 : 6;
    return P_UNIT * mult;
  endfunction

  function automatic int f_frame(int r, int f);
    int d;
    d = f_line(r) * ((f == 0) ? P_FA : P_FB);
    return (P_CLK + d / 2) / d;
  endfunction

  function automatic int f_hsw(int r);
    int v;
    v = f_line(r) * P_HPCT / 100;
    return (v < 1) ? 1 : v;
  endfunction

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check_outputs();
    bit eh, ev, act, grid, evid;
    int L, F, hs, ax, ay;
    string tag;
    L  = f_line(m_rate);
    F  = f_frame(m_rate, m_frm);
    hs = f_hsw(m_rate);
    eh = m_run && (m_x < hs);
    ev = m_run && (m_y < P_VSL);
    act = m_run && !eh && !ev;
    ax = m_x - hs;
    ay = m_y - P_VSL;
    grid = (ax % (1 << P_HL) == 0) || (ay % (1 << P_HL) == 0) || (m_x == L - 1) || (m_y == F - 1);
    case (m_pat)
      0: evid = act && grid;         // R6
      1: evid = act && !grid;        // R7
      2: evid = act;                 // R8
      default: evid = 1'b0;          // R8
    endcase
    checks++;
    if (h_out !== eh || v_out !== ev || video_out !== evid) begin
      fails++;
      if (phase != "")        tag = phase;
      else if (h_out !== eh)  tag = "R2/R4";
      else if (v_out !== ev)  tag = "R3/R5";
      else if (!act)          tag = "R9";
      else if (m_pat == 0)    tag = "R6";
      else if (m_pat == 1)    tag = "R7";
      else                    tag = "R8";
      $display("FAIL %s: h,v,video actual %b%b%b expected %b%b%b (x=%0d y=%0d rate=%0d frm=%0d pat=%0d)",
               tag, h_out, v_out, video_out, eh, ev, evid, m_x, m_y, m_rate, m_frm, m_pat);
    end
  endtask

  // Advance the model over the coming edge, then sample at the falling edge.
  task automatic tick();
    bit go, le, fe, load;
    int L, F, nx, ny;
    if (rst_n) begin
      L    = f_line(m_rate);
      F    = f_frame(m_rate, m_frm);
      go   = m_run && en;
      le   = go && (m_x == L - 1);
      fe   = le && (m_y == F - 1);
      load = !m_run || fe;
      nx   = (!go || le) ? 0 : m_x + 1;
      ny   = !go ? 0 : (le ? (fe ? 0 : m_y + 1) : m_y);
      m_x  = nx;
      m_y  = ny;
      if (load) begin
        m_rate = rate_sel;
        m_frm  = frame_sel;
        m_pat  = pat_sel;
      end
      m_run = en;
      m_fe  = fe;
    end else begin
      m_fe = 0;
    end
    @(negedge clk);
    check_outputs();
  endtask

  task automatic run_frames(int n);
    int seen;
    seen = 0;
    while (seen < n) begin
      tick();
      if (m_fe) seen++;
    end
  endtask

  task automatic set_sel(int r, int f, int p);
    rate_sel  = 2'(r);
    frame_sel = 1'(f);
    pat_sel   = 2'(p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual running, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b1;
    set_sel(1, 1, 2);
    // R1: outputs quiet while reset is held, even with enable high.
    phase = "R1";
    repeat (4) tick();
    en = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (6) tick();
    phase = "";

    // Sweep every rate, frame rate and picture over two frames each.
    for (int r = 0; r < 4; r++) begin
      for (int f = 0; f < 2; f++) begin
        for (int p = 0; p < 4; p++) begin
          set_sel(r, f, p);
          en = 1'b1;
          run_frames(2);
        end
      end
    end

    // R10: selection changes in mid-frame wait for the next frame.
    phase = "R10";
    set_sel(0, 0, 0);
    run_frames(1);
    repeat (37) tick();
    set_sel(2, 1, 1);
    run_frames(2);
    repeat (5) tick();
    set_sel(3, 0, 2);
    repeat (11) tick();
    set_sel(0, 1, 0);
    run_frames(2);

    // R11: enable dropped mid-frame, then restored with new selections.
    phase = "R11";
    repeat (23) tick();
    en = 1'b0;
    repeat (5) tick();
    set_sel(1, 0, 1);
    en = 1'b1;
    run_frames(1);
    repeat (50) tick();
    en = 1'b0;
    tick();
    en = 1'b1;
    run_frames(1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule